// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block sits beside the command sequencer of an SDRAM controller. When a READ or WRITE is issued, the sequencer pulses a start strobe. With it come the starting column, the access direction and the auto-precharge request. The generator then produces the column address for every data beat of the burst. It follows the burst length, the burst ordering and the write-burst setting that were programmed into the device's mode register.

Fixed-length bursts of 1, 2, 4 or 8 columns stay inside the aligned block that holds the starting column. Only the low column bits move, either by counting up with wrap-around (sequential) or by XOR with the beat number (interleaved). The full-page setting runs sequentially through all 512 columns of the open row, wrapping within the row, until a burst-terminate arrives. A last-beat flag marks the final beat of each fixed burst. A second flag marks the beat after which an auto precharge may begin. Mode settings that the device does not define are rejected with an error pulse.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `beat_vld`, `cfg_err` and `ap_ok` are low.
- R2: A start sampled at clock edge k yields the first beat in the cycle after edge k, with `beat_col` equal to the starting column and `beat_idx` equal to 0. Each later beat raises `beat_idx` by one, with no gap.
- R3: Length code (`mode_len`) 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `beat_last` is high on the final beat only, and `beat_vld` is low in the cycle after it.
- R4: In sequential order (`mode_ilv` = 0), the column bits above the block offset keep their start value. The offset bits count up from the start offset, modulo the burst length.
- R5: In interleaved order (`mode_ilv` = 1), beat i addresses the starting column XOR i.
- R6: Length code 7 with sequential order is full page. The column of beat i is (start + i) mod 512. `beat_last` never rises, and beats continue until terminated.
- R7: Length codes 4, 5 and 6, and code 7 with interleaved order, are rejected. `cfg_err` is high for exactly the one cycle after the start, no beat is produced, and any running burst is dropped.
- R8: With `mode_wr_single` = 1, a write start yields one beat flagged last, while a read keeps the programmed length. With `mode_wr_single` = 0, writes use the programmed length.
- R9: `term` high at a clock edge, with no start, ends the running burst. No beat is valid in the following cycle.
- R10: A start during a running burst drops the old burst at that edge, and the new sequence begins in the next cycle.
- R11: `ap_ok` is high only on the last beat of a fixed-length burst whose start carried `start_ap` = 1. It never rises in full-page bursts.
- R12: Mode inputs are sampled only with the start, so changing them during a burst does not alter that burst's columns or length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_len | input | 3 | Burst length code: 0/1/2/3 = 1/2/4/8, 7 = full page, others reserved |
| mode_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| mode_wr_single | input | 1 | 1 = writes are single-location |
| start | input | 1 | READ/WRITE issued this cycle |
| start_write | input | 1 | 1 = the started access is a write |
| start_ap | input | 1 | Auto precharge requested with the access |
| start_col | input | 9 | Starting column |
| term | input | 1 | Burst terminate |
| beat_vld | output | 1 | A beat is valid this cycle |
| beat_col | output | 9 | Column of the current beat |
| beat_idx | output | 9 | Beat number within the burst |
| beat_last | output | 1 | Final beat of a fixed-length burst |
| ap_ok | output | 1 | Auto precharge may begin after this beat |
| cfg_err | output | 1 | Previous start carried an undefined mode |

## Verification
On every cycle, the assertions check that a start leads either to a first beat at the start column with index zero or to an error pulse. They also check that an error never coexists with a beat, that beats advance one index at a time until the last beat or a terminate, and that `ap_ok` appears only on a last beat. The actual column orderings can only be shown by the bench's scenarios. These cover wrap points inside aligned blocks, XOR ordering, the full-page wrap past column 511, single-beat writes, mid-burst mode changes and restarts, since each depends on the start column and mode chosen.

// File: rtl/colgen_pkg.sv
`timescale 1ns/1ps
package colgen_pkg;
  localparam int COL_W     = 9;
  localparam int CODE_W    = 3;
  localparam int MAX_LOG2  = 3;  // largest fixed burst is 2**MAX_LOG2
  localparam logic [CODE_W-1:0] CODE_FULL = 3'd7;

  typedef enum logic [1:0] {
    CFG_FIXED = 2'd0,
    CFG_FULL  = 2'd1,
    CFG_BAD   = 2'd2
  } cfg_kind_e;
endpackage

// File: rtl/colgen_decode.sv
`timescale 1ns/1ps
module colgen_decode
  import colgen_pkg::*;
#(
  parameter int COLW = COL_W
) (
  input  logic [CODE_W-1:0] len_code,
  input  logic              ilv,
  input  logic              wr_single,
  input  logic              is_write,
  output cfg_kind_e         kind,
  output logic [COLW-1:0]   mask
);
  localparam logic [COLW-1:0] ALL_ONES = '1;

  always_comb begin
    kind = CFG_BAD;
    mask = '0;
    if (len_code == CODE_FULL) begin
      if (!ilv) begin
        kind = CFG_FULL;
        mask = ALL_ONES;
      end
    end else if (len_code[CODE_W-1] == 1'b0) begin
      kind = CFG_FIXED;
      mask = COLW'((32'd1 << len_code[1:0]) - 32'd1);
    end
    if (kind != CFG_BAD && wr_single && is_write) begin
      kind = CFG_FIXED;
      mask = '0;
    end
  end
endmodule

// File: rtl/colgen_addr.sv
`timescale 1ns/1ps
module colgen_addr #(
  parameter int COLW = 9
) (
  input  logic [COLW-1:0] base,
  input  logic [COLW-1:0] idx,
  input  logic [COLW-1:0] mask,
  input  logic            ilv,
  output logic [COLW-1:0] col
);
  logic [COLW-1:0] sum;
  assign sum = base + idx;

  for (genvar b = 0; b < COLW; b++) begin : g_bit
    always_comb begin
      if (!mask[b])
        col[b] = base[b];
      else if (ilv)
        col[b] = base[b] ^ idx[b];
      else
        col[b] = sum[b];
    end
  end
endmodule

// File: rtl/colgen_seq.sv
`timescale 1ns/1ps
module colgen_seq
  import colgen_pkg::*;
#(
  parameter int COLW = COL_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  cfg_kind_e       kind,
  input  logic [COLW-1:0] mask_in,
  input  logic            ilv_in,
  input  logic            ap_in,
  input  logic [COLW-1:0] col_in,
  input  logic            term,
  output logic            act,
  output logic [COLW-1:0] idx,
  output logic [COLW-1:0] mask,
  output logic            full,
  output logic            ilv,
  output logic            ap,
  output logic [COLW-1:0] base,
  output logic            err
);
  logic            act_d, err_d, load_en, adv_en;
  logic [COLW-1:0] idx_d;
  logic            at_end;

  assign at_end = !full && (idx == mask);

  always_comb begin
    act_d   = act;
    idx_d   = idx;
    err_d   = 1'b0;
    load_en = 1'b0;
    adv_en  = 1'b0;
    if (start) begin
      if (kind == CFG_BAD) begin
        act_d = 1'b0;
        err_d = 1'b1;
      end else begin
        act_d   = 1'b1;
        idx_d   = '0;
        load_en = 1'b1;
      end
    end else if (act) begin
      if (term || at_end) begin
        act_d = 1'b0;
      end else begin
        adv_en = 1'b1;
        idx_d  = idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act <= 1'b0;
      err <= 1'b0;
      idx <= '0;
    end else begin
      act <= act_d;
      err <= err_d;
      if (load_en || adv_en) idx <= idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
      full <= 1'b0;
      ilv  <= 1'b0;
      ap   <= 1'b0;
      base <= '0;
    end else if (load_en) begin
      mask <= mask_in;
      full <= (kind == CFG_FULL);
      ilv  <= ilv_in;
      ap   <= ap_in;
      base <= col_in;
    end
  end
endmodule

// File: rtl/sdram_burst_colgen.sv
`timescale 1ns/1ps
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int COLW = COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] mode_len,
  input  logic              mode_ilv,
  input  logic              mode_wr_single,
  input  logic              start,
  input  logic              start_write,
  input  logic              start_ap,
  input  logic [COLW-1:0]   start_col,
  input  logic              term,
  output logic              beat_vld,
  output logic [COLW-1:0]   beat_col,
  output logic [COLW-1:0]   beat_idx,
  output logic              beat_last,
  output logic              ap_ok,
  output logic              cfg_err
);
  cfg_kind_e       kind;
  logic [COLW-1:0] dec_mask, q_mask, q_base, q_idx;
  logic            q_act, q_full, q_ilv, q_ap, q_err;

  colgen_decode #(.COLW(COLW)) u_dec (
    .len_code (mode_len),
    .ilv      (mode_ilv),
    .wr_single(mode_wr_single),
    .is_write (start_write),
    .kind     (kind),
    .mask     (dec_mask)
  );

  colgen_seq #(.COLW(COLW)) u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .kind   (kind),
    .mask_in(dec_mask),
    .ilv_in (mode_ilv),
    .ap_in  (start_ap),
    .col_in (start_col),
    .term   (term),
    .act    (q_act),
    .idx    (q_idx),
    .mask   (q_mask),
    .full   (q_full),
    .ilv    (q_ilv),
    .ap     (q_ap),
    .base   (q_base),
    .err    (q_err)
  );

  colgen_addr #(.COLW(COLW)) u_addr (
    .base(q_base),
    .idx (q_idx),
    .mask(q_mask),
    .ilv (q_ilv),
    .col (beat_col)
  );

  assign beat_vld  = q_act;
  assign beat_idx  = q_idx;
  assign beat_last = q_act && !q_full && (q_idx == q_mask);
  assign ap_ok     = beat_last && q_ap;
  assign cfg_err   = q_err;
endmodule

// File: rtl/sdram_burst_colgen_chk.sv
`timescale 1ns/1ps
module sdram_burst_colgen_chk #(
  parameter int COLW = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [COLW-1:0] start_col,
  input logic            term,
  input logic            beat_vld,
  input logic [COLW-1:0] beat_col,
  input logic [COLW-1:0] beat_idx,
  input logic            beat_last,
  input logic            ap_ok,
  input logic            cfg_err
);
  // R2
  first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (beat_vld && beat_col == $past(start_col) && beat_idx == '0) || cfg_err);

  // R2
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld && !beat_last && !start && !term |=> beat_vld && beat_idx == $past(beat_idx) + 1'b1);

  // R3
  end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_vld && beat_last && !start |=> !beat_vld);

  // R7
  err_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !beat_vld);

  // R9
  term_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term && !start |=> !beat_vld);

  // R11
  ap_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ap_ok |-> beat_vld && beat_last);
endmodule

bind sdram_burst_colgen sdram_burst_colgen_chk #(.COLW(COLW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .start_col(start_col),
  .term     (term),
  .beat_vld (beat_vld),
  .beat_col (beat_col),
  .beat_idx (beat_idx),
  .beat_last(beat_last),
  .ap_ok    (ap_ok),
  .cfg_err  (cfg_err)
);

// File: tb/sdram_burst_colgen_bench.sv
`timescale 1ns/1ps
module sdram_burst_colgen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_len = '0;
  logic       mode_ilv = 1'b0, mode_wr_single = 1'b0;
  logic       start = 1'b0, start_write = 1'b0, start_ap = 1'b0, term = 1'b0;
  logic [8:0] start_col = '0;
  logic       beat_vld, beat_last, ap_ok, cfg_err;
  logic [8:0] beat_col, beat_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdram_burst_colgen u_sdram_burst_colgen (
    .clk(clk), .rst_n(rst_n), .mode_len(mode_len), .mode_ilv(mode_ilv),
    .mode_wr_single(mode_wr_single), .start(start), .start_write(start_write),
    .start_ap(start_ap), .start_col(start_col), .term(term),
    .beat_vld(beat_vld), .beat_col(beat_col), .beat_idx(beat_idx),
    .beat_last(beat_last), .ap_ok(ap_ok), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_col(input int len, input bit ilv, input int s, input int i);
    int off, blk;
    if (len == 512) return (s + i) % 512;
    if (ilv) return s ^ i;
    off = s % len;
    blk = s - off;
    return blk + ((off + i) % len);
  endfunction

  // Runs one burst from the current negedge; len is the expected length (512 = full page)
  task automatic burst(input string req, input logic [2:0] code, input bit ilv, input bit wr,
                       input bit ap, input int col, input int len, input int term_at,
                       input bit mid_change);
    int n_exp, i;
    bit exp_last;
    mode_len = code; mode_ilv = ilv; start_write = wr; start_ap = ap;
    start_col = col[8:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n_exp = (term_at >= 0) ? term_at + 1 : len;
    i = 0;
    while (beat_vld && i < 2000) begin
      exp_last = (len != 512) && (i == len - 1);
      chk(beat_col == exp_col(len, ilv, col, i), req, "column", beat_col, exp_col(len, ilv, col, i));
      chk(beat_idx == i[8:0], req, "beat index", beat_idx, i % 512);
      chk(beat_last == exp_last, req, "last flag", beat_last, exp_last);
      chk(ap_ok == (exp_last && ap), req, "ap_ok", ap_ok, exp_last && ap);
      if (mid_change && i == 0) begin mode_len = 3'd0; mode_ilv = ~ilv; end
      if (i == term_at) term = 1'b1;
      @(negedge clk);
      term = 1'b0;
      i++;
    end
    chk(i == n_exp, req, "beat count", i, n_exp);
  endtask

  task automatic t_reset;
    chk(!beat_vld && !cfg_err && !ap_ok, "R1", "outputs in reset", {beat_vld, cfg_err, ap_ok}, 0);
    @(negedge clk); rst_n = 1'b1;
    chk(!beat_vld && !cfg_err && !ap_ok, "R1", "outputs after reset", {beat_vld, cfg_err, ap_ok}, 0);
  endtask

  task automatic t_sequential;
    burst("R2", 3'd0, 0, 0, 0, 9'h0A5, 1, -1, 0);
    burst("R3", 3'd1, 0, 0, 0, 9'h033, 2, -1, 0);
    burst("R4", 3'd2, 0, 0, 0, 9'h01D, 4, -1, 0);
    burst("R4", 3'd3, 0, 0, 0, 9'h00D, 8, -1, 0);
    burst("R3", 3'd3, 0, 0, 0, 9'h1F8, 8, -1, 0);
  endtask

  task automatic t_interleaved;
    burst("R5", 3'd3, 1, 0, 0, 9'h00D, 8, -1, 0);
    burst("R5", 3'd2, 1, 0, 0, 9'h01E, 4, -1, 0);
    burst("R5", 3'd1, 1, 0, 0, 9'h101, 2, -1, 0);
  endtask

  task automatic t_full_page;
    burst("R6", 3'd7, 0, 0, 1, 9'h1FE, 512, 599, 0);
  endtask

  task automatic t_reserved;
    for (int c = 4; c < 8; c++) begin
      mode_len = c[2:0]; mode_ilv = (c == 7); start_col = 9'h040; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(cfg_err && !beat_vld, "R7", "reject pulse", {cfg_err, beat_vld}, 2);
      @(negedge clk);
      chk(!cfg_err && !beat_vld, "R7", "after reject", {cfg_err, beat_vld}, 0);
    end
    mode_len = 3'd3; mode_ilv = 1'b0; start_col = 9'h080; start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    mode_len = 3'd5; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk(cfg_err && !beat_vld, "R7", "reject drops running burst", {cfg_err, beat_vld}, 2);
    @(negedge clk);
    chk(!beat_vld, "R7", "no beat after drop", beat_vld, 0);
  endtask

  task automatic t_write_mode;
    mode_wr_single = 1'b1;
    burst("R8", 3'd3, 0, 1, 0, 9'h015, 1, -1, 0);
    burst("R8", 3'd7, 0, 1, 0, 9'h015, 1, -1, 0);
    burst("R8", 3'd3, 0, 0, 0, 9'h015, 8, -1, 0);
    mode_wr_single = 1'b0;
    burst("R8", 3'd2, 0, 1, 0, 9'h015, 4, -1, 0);
  endtask

  task automatic t_terminate;
    burst("R9", 3'd3, 0, 0, 1, 9'h06B, 8, 2, 0);
  endtask

  task automatic t_restart;
    mode_len = 3'd3; mode_ilv = 1'b0; start_write = 1'b0; start_col = 9'h010; start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 3; i++) begin
      chk(beat_vld && beat_col == 9'(16 + i), "R10", "first burst column", beat_col, 16 + i);
      if (i < 2) @(negedge clk);
    end
    burst("R10", 3'd1, 0, 0, 0, 9'h045, 2, -1, 0);
  endtask

  task automatic t_auto_pre;
    burst("R11", 3'd2, 0, 0, 1, 9'h12E, 4, -1, 0);
    burst("R11", 3'd7, 0, 0, 1, 9'h0F0, 512, 20, 0);
  endtask

  task automatic t_mode_hold;
    burst("R12", 3'd3, 0, 0, 0, 9'h0C3, 8, -1, 1);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_sequential();
    t_interleaved();
    t_full_page();
    t_reserved();
    t_write_mode();
    t_terminate();
    t_restart();
    t_auto_pre();
    t_mode_hold();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule